// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte that a host sees on reads while an internal program or erase operation is running. During an operation the host gets a status word instead of array contents. Bit 7 is a polling bit, bit 6 inverts on every read, bit 5 flags a time overrun, bit 4 names the failing phase and bit 3 shows whether the sector erase window has closed. When the operation ends, the block returns to plain array reads by itself.

Byte programming is timed inside the block with a counter of clock cycles. At the end of the program pulse the block issues a single write of the old byte ANDed with the new byte, because programming can only clear bits. If that result differs from the requested value, the operation keeps running until the time limit and then fails. A failed operation holds the status view until a reset command arrives. Erase timing belongs to an external engine, which reports busy, window, phase and overrun levels. Array storage and command decoding sit outside this block.

Top module: `opstat_reporter`

## Requirements
- R1: After reset, and whenever no operation is active or failed, `rd_data` equals `array_byte`, `prog_we` is low, and read strobes change nothing.
- R2: In the cycles after a program start, `rd_data` bit 7 is the complement of bit 7 of the latched program value, and bits 5, 4, 3 and 2..0 read 0.
- R3: Bit 6 is 0 on the first status read after an operation starts. It inverts after each clock edge that has `rd_strobe` high while status is shown, and holds without a strobe.
- R4: `prog_we` is high for exactly one cycle, the PGM_CYCLES-th cycle after the start edge, with `prog_wdata` equal to old byte AND new byte.
- R5: When the ANDed result equals the requested value, array reads resume in the cycle after the write.
- R6: When the result differs, status is shown with bit 5 at 0 up to cycle LIMIT_CYCLES after the start edge. The block then fails with bit 5 = 1, bit 4 = 0, bit 3 = 0 and bit 7 still the complemented polling value.
- R7: A failed state persists, ignores `start_pgm`, and leaves to array reads only on the edge where `reset_cmd` is high.
- R8: While the erase engine is busy, bit 7 reads 0. With the window open, bits 4 and 3 read 0. In preprogram (window closed, `ers_erasing` low), bit 3 = 1 and bit 4 = 0. In the erase phase, both bits read 1.
- R9: When `ers_busy` falls during an erase, array reads resume on the next cycle.
- R10: An `ers_overrun` during an erase fails the block with bit 7 = 0, bit 5 = 1, bit 3 = 1 and bit 4 set to the phase latched at the overrun.
- R11: While a program or erase is running, `start_pgm` and `reset_cmd` have no effect on the status byte or on `prog_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pgm | input | 1 | Begin byte program (accepted only in array mode) |
| pgm_data | input | 8 | Value requested to be programmed |
| array_byte | input | 8 | Current array byte at the read/program address |
| ers_busy | input | 1 | Erase engine is running |
| ers_window | input | 1 | Sector erase collection window still open |
| ers_erasing | input | 1 | Engine in the erase phase (0 = preprogram) |
| ers_overrun | input | 1 | Engine reports the erase time limit exceeded |
| rd_strobe | input | 1 | One host read in this cycle |
| reset_cmd | input | 1 | Reset command leaves the failed state |
| rd_data | output | 8 | Read data: array byte or status word |
| prog_we | output | 1 | One-cycle write of the programmed result |
| prog_wdata | output | 8 | Programmed result, old AND new |

## Verification
Program runs are driven with old/new byte pairs. Some pairs only clear bits, some try to raise a 0 to 1, and some have bit 7 of the new value both high and low. This shows that the polling bit follows the requested value rather than the array, and it separates clean completion from a timed-out failure. Erase runs walk the window, preprogram and erase phases, so each of bits 3 and 4 is checked separately, and one run ends in an overrun after the phase input has changed, which shows that the phase is latched. Stray start and reset commands are injected during busy and failed periods to confirm they are ignored or obeyed as required.

// File: rtl/opstat_pkg.sv
// Shared definitions for the embedded operation status reporter.
// Assumes one operation at a time; status bit positions are fixed by the host polling protocol.
package opstat_pkg;
    typedef enum logic [1:0] {
        ST_ARRAY = 2'd0,
        ST_PGM   = 2'd1,
        ST_ERS   = 2'd2,
        ST_FAIL  = 2'd3
    } op_state_e;

    localparam int POLL_BIT  = 7;
    localparam int TOG_BIT   = 6;
    localparam int LIMIT_BIT = 5;
    localparam int PHASE_BIT = 4;
    localparam int WIN_BIT   = 3;
endpackage

// File: rtl/opstat_pgm_timer.sv
// Program duration counter: marks the end of the program pulse and the time limit.
// Assumes LIMIT > PULSE >= 1; clear wins over run.
module opstat_pgm_timer #(
    parameter int PULSE = 8,
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic pulse_end,
    output logic limit_end
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent programming.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end

    assign pulse_end = run && (cnt_q == CW'(PULSE - 1));
    assign limit_end = run && (cnt_q == CW'(LIMIT - 1));

    // R6: the counter never runs past the limit while programming
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/opstat_toggle.sv
// Read-driven toggle bit: cleared when an operation starts, inverted per status read.
// Assumes clear and advance are never high together in a correct caller.
module opstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog
);
    // Hold or invert the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        tog <= 1'b0;
        else if (clear)    tog <= 1'b0;
        else if (advance)  tog <= ~tog;
    end

    // R3: a start must not coincide with a counted read
    a_r3_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !advance);
endmodule

// File: rtl/opstat_fmt.sv
// Read data former: passes the array byte or builds the status word from mode and flags.
// Purely combinational; reserved bits 2..0 read 0 in status.
module opstat_fmt
    import opstat_pkg::*;
(
    input  op_state_e  state,
    input  logic       tog,
    input  logic       want7,
    input  logic [7:0] array_byte,
    input  logic       ers_window,
    input  logic       ers_erasing,
    input  logic       fail_erase,
    input  logic       fail_phase,
    output logic [7:0] rd_data
);
    // Select the array byte or assemble the status bits.
    always_comb begin
        rd_data = 8'h00;
        case (state)
            ST_PGM: begin
                rd_data[POLL_BIT] = ~want7;
                rd_data[TOG_BIT]  = tog;
            end
            ST_ERS: begin
                rd_data[TOG_BIT]   = tog;
                rd_data[PHASE_BIT] = ~ers_window & ers_erasing;
                rd_data[WIN_BIT]   = ~ers_window;
            end
            ST_FAIL: begin
                rd_data[POLL_BIT]  = fail_erase ? 1'b0 : ~want7;
                rd_data[TOG_BIT]   = tog;
                rd_data[LIMIT_BIT] = 1'b1;
                rd_data[PHASE_BIT] = fail_erase & fail_phase;
                rd_data[WIN_BIT]   = fail_erase;
            end
            default: rd_data = array_byte;
        endcase
    end
endmodule

// File: rtl/opstat_reporter.sv
// Top of the status reporter: mode control, program effect and timeout, erase tracking.
// Assumes array_byte is stable while start_pgm is sampled and the erase engine drives levels.
module opstat_reporter
    import opstat_pkg::*;
#(
    parameter int PGM_CYCLES   = 8,
    parameter int LIMIT_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_pgm,
    input  logic [7:0] pgm_data,
    input  logic [7:0] array_byte,
    input  logic       ers_busy,
    input  logic       ers_window,
    input  logic       ers_erasing,
    input  logic       ers_overrun,
    input  logic       rd_strobe,
    input  logic       reset_cmd,
    output logic [7:0] rd_data,
    output logic       prog_we,
    output logic [7:0] prog_wdata
);
    op_state_e  state_q, state_d;
    logic [7:0] old_q, new_q;
    logic       fail_erase_q, fail_phase_q;
    logic       pgm_go, ers_go, pulse_end, limit_end, tog, match;

    assign pgm_go = (state_q == ST_ARRAY) && start_pgm;
    assign ers_go = (state_q == ST_ARRAY) && !start_pgm && ers_busy;
    assign match  = ((new_q & ~old_q) == 8'h00);

    // Next operating mode.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_ARRAY: if (start_pgm) state_d = ST_PGM;
                      else if (ers_busy) state_d = ST_ERS;
            ST_PGM:   if (limit_end) state_d = ST_FAIL;
                      else if (pulse_end && match) state_d = ST_ARRAY;
            ST_ERS:   if (ers_overrun) state_d = ST_FAIL;
                      else if (!ers_busy) state_d = ST_ARRAY;
            ST_FAIL:  if (reset_cmd) state_d = ST_ARRAY;
            default:  state_d = ST_ARRAY;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARRAY;
        else        state_q <= state_d;
    end

    // Latch the old and requested bytes at program start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= 8'h00;
            new_q <= 8'h00;
        end else if (pgm_go) begin
            old_q <= array_byte;
            new_q <= pgm_data;
        end
    end

    // Record which operation and phase ran into the time limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_erase_q <= 1'b0;
            fail_phase_q <= 1'b0;
        end else if (state_q == ST_PGM && limit_end) begin
            fail_erase_q <= 1'b0;
            fail_phase_q <= 1'b0;
        end else if (state_q == ST_ERS && ers_overrun) begin
            fail_erase_q <= 1'b1;
            fail_phase_q <= ers_erasing;
        end
    end

    opstat_pgm_timer #(.PULSE(PGM_CYCLES), .LIMIT(LIMIT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pgm_go),
        .run       (state_q == ST_PGM),
        .pulse_end (pulse_end),
        .limit_end (limit_end)
    );

    opstat_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pgm_go || ers_go),
        .advance (rd_strobe && (state_q != ST_ARRAY)),
        .tog     (tog)
    );

    opstat_fmt u_fmt (
        .state       (state_q),
        .tog         (tog),
        .want7       (new_q[7]),
        .array_byte  (array_byte),
        .ers_window  (ers_window),
        .ers_erasing (ers_erasing),
        .fail_erase  (fail_erase_q),
        .fail_phase  (fail_phase_q),
        .rd_data     (rd_data)
    );

    assign prog_we    = (state_q == ST_PGM) && pulse_end;
    assign prog_wdata = old_q & new_q;

    // R4: the program result is written in one cycle only
    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> !prog_we);

    // R2: while programming, the polling bit opposes the requested bit 7
    a_r2_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGM) |-> (rd_data[POLL_BIT] != new_q[POLL_BIT]));

    // R3: a counted status read inverts bit 6 by the next cycle
    a_r3_toggle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARRAY && rd_strobe)
        |=> (state_q == ST_ARRAY || rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

    // R7: without a reset command the failed state holds
    a_r7_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL && !reset_cmd) |=> (state_q == ST_FAIL));

    // R9: erase completion returns to array reads
    a_r9_erase_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERS && !ers_busy && !ers_overrun) |=> (state_q == ST_ARRAY));

    // R6: failure is entered only from a running operation
    a_r6_fail_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARRAY) |=> (state_q != ST_FAIL));
endmodule

// File: tb/sim_opstat_reporter.sv
module sim_opstat_reporter;
    localparam int PGM_CYCLES   = 8;
    localparam int LIMIT_CYCLES = 20;
    localparam int NVEC = 5;
    // each entry: {old byte, requested byte}
    localparam logic [15:0] VEC [NVEC] = '{16'hFF5A, 16'hF030, 16'h0FF0, 16'h8000, 16'hAA55};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_pgm = 1'b0;
    logic [7:0] pgm_data = 8'h00;
    logic [7:0] array_byte = 8'h3C;
    logic       ers_busy = 1'b0, ers_window = 1'b0, ers_erasing = 1'b0, ers_overrun = 1'b0;
    logic       rd_strobe = 1'b0, reset_cmd = 1'b0;
    logic [7:0] rd_data, prog_wdata;
    logic       prog_we;
    int         n_chk = 0, n_bad = 0;
    bit         ended = 1'b0;

    always #5 clk = ~clk;

    opstat_reporter #(.PGM_CYCLES(PGM_CYCLES), .LIMIT_CYCLES(LIMIT_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .pgm_data(pgm_data),
        .array_byte(array_byte), .ers_busy(ers_busy), .ers_window(ers_window),
        .ers_erasing(ers_erasing), .ers_overrun(ers_overrun), .rd_strobe(rd_strobe),
        .reset_cmd(reset_cmd), .rd_data(rd_data), .prog_we(prog_we), .prog_wdata(prog_wdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) tick();
        #1 chk("R1 in reset", rd_data, 8'h3C);
        rst_n = 1'b1;
        tick();
        rd_strobe = 1'b1;
        #1 chk("R1 after reset", rd_data, 8'h3C);
        chk("R1 no write", {7'd0, prog_we}, 8'h00);
        tick();
        rd_strobe = 1'b0;
        #1 chk("R1 strobe in array mode", rd_data, 8'h3C);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] ov, nv, res;
            ov  = VEC[v][15:8];
            nv  = VEC[v][7:0];
            res = ov & nv;
            tick();
            array_byte = ov; pgm_data = nv; start_pgm = 1'b1;
            tick();
            start_pgm = 1'b0; rd_strobe = 1'b1;
            #1 chk("R2 first status", rd_data, {~nv[7], 7'h00});
            tick();
            rd_strobe = 1'b0;
            #1 chk("R3 bit6 after read", {7'd0, rd_data[6]}, 8'h01);
            chk("R4 no early write", {7'd0, prog_we}, 8'h00);
            repeat (PGM_CYCLES - 2) tick();
            #1 chk("R4 write strobe", {7'd0, prog_we}, 8'h01);
            chk("R4 write value", prog_wdata, res);
            tick();
            array_byte = res;
            #1 chk("R4 strobe gone", {7'd0, prog_we}, 8'h00);
            if (res == nv) begin
                chk("R5 array read resumes", rd_data, res);
            end else begin
                chk("R6 still busy", rd_data, {~nv[7], 7'h40});
                repeat (LIMIT_CYCLES - 1 - PGM_CYCLES) tick();
                #1 chk("R6 busy at limit", rd_data, {~nv[7], 7'h40});
                tick();
                rd_strobe = 1'b1;
                #1 chk("R6 failed status", rd_data, {~nv[7], 7'h60});
                tick();
                rd_strobe = 1'b0; start_pgm = 1'b1; pgm_data = ~nv;
                #1 chk("R3 toggle in fail", rd_data, {~nv[7], 7'h20});
                tick();
                start_pgm = 1'b0;
                #1 chk("R7 start ignored", rd_data, {~nv[7], 7'h20});
                chk("R7 no write", {7'd0, prog_we}, 8'h00);
                reset_cmd = 1'b1;
                tick();
                reset_cmd = 1'b0;
                #1 chk("R7 reset to array", rd_data, res);
            end
        end

        // erase walk with stray commands
        array_byte = 8'hC3;
        tick();
        ers_busy = 1'b1; ers_window = 1'b1; ers_erasing = 1'b0;
        tick();
        rd_strobe = 1'b1;
        #1 chk("R8 window open", rd_data, 8'h00);
        tick();
        rd_strobe = 1'b0; reset_cmd = 1'b1; start_pgm = 1'b1; pgm_data = 8'h00;
        #1 chk("R3 erase toggle", rd_data, 8'h40);
        tick();
        reset_cmd = 1'b0; start_pgm = 1'b0;
        #1 chk("R11 commands ignored", rd_data, 8'h40);
        repeat (PGM_CYCLES) begin
            tick();
            #1 chk("R11 no write during erase", {7'd0, prog_we}, 8'h00);
        end
        ers_window = 1'b0;
        #1 chk("R8 preprogram", rd_data, 8'h48);
        ers_erasing = 1'b1;
        #1 chk("R8 erase phase", rd_data, 8'h58);
        tick();
        ers_busy = 1'b0;
        tick();
        #1 chk("R9 erase done", rd_data, 8'hC3);

        // erase overrun, phase changes after the overrun
        ers_busy = 1'b1; ers_window = 1'b0; ers_erasing = 1'b1;
        tick();
        ers_overrun = 1'b1;
        tick();
        ers_overrun = 1'b0; ers_busy = 1'b0; ers_erasing = 1'b0;
        #1 chk("R10 erase failed", rd_data, 8'h38);
        tick();
        #1 chk("R7 fail persists", rd_data, 8'h38);
        reset_cmd = 1'b1;
        tick();
        reset_cmd = 1'b0;
        #1 chk("R7 reset after erase fail", rd_data, 8'hC3);

        wrap_up();
    end
endmodule